// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block is a purely combinational binary adder of parameterised width. The width must be a multiple of four. It takes two operands and a carry input and returns their sum and carry-out. It avoids a bit-to-bit carry chain. Every bit position derives two local terms from its own operand bits: a generate term (both bits set) and a propagate term (either bit set). The operands are split into four-bit groups, and each group computes all four of its stage carries as flat sums of products of those terms and its group carry input.

Each group also produces a group generate and a group propagate. A second lookahead level turns these into every group carry input directly from the block carry input, as flat sums of products. The worst-case carry depth therefore grows with the number of groups only at the second level, and never by one stage per bit. Each sum bit is then formed as generate XOR propagate XOR the carry entering that position.

Besides the sum and the carry-out, the block exposes the carry that enters the most significant bit. A user can XOR it with the carry-out to flag signed overflow without a second adder. Operand selection and registering belong to the surrounding datapath.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `op_a + op_b + carry_in`, treated as unsigned numbers.
- R2: `carry_out` equals bit WIDTH of the unsigned total `op_a + op_b + carry_in`, so it is 1 exactly when that total exceeds 2^WIDTH - 1.
- R3: `carry_msb_in` equals the carry entering bit WIDTH-1. This is bit WIDTH-1 of `op_a[WIDTH-2:0] + op_b[WIDTH-2:0] + carry_in`. The top sum bit then equals `op_a[WIDTH-1] ^ op_b[WIDTH-1] ^ carry_msb_in`.
- R4: `carry_out ^ carry_msb_in` is 1 exactly when the operands, read as two's-complement numbers, have the same sign bit and `sum[WIDTH-1]` differs from that sign bit.
- R5: When every bit position propagates without generating (`op_a ^ op_b` all ones), `carry_in` travels through the full width. `carry_out` equals `carry_in`, and `sum` is all ones when `carry_in` is 0 and all zeros when it is 1.
- R6: With both operands and `carry_in` at 0, `sum`, `carry_out` and `carry_msb_in` are all 0.
- R7: R1 to R4 hold for WIDTH 4 (a single group), 16 and 32, with the group carries produced by the second lookahead level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of bit WIDTH-1 |
| carry_msb_in | output | 1 | Carry into bit WIDTH-1, for overflow detection |

## Verification
The assertions assume that all inputs are two-state and settled whenever the outputs are compared. They also assume that WIDTH is at least 4 and a multiple of four, so that a lower slice of WIDTH-1 bits exists for the sign-carry reference. The stimulus keeps within these limits. It drives inputs only on one clock edge and compares on the opposite edge, and it instantiates the adder only at widths 4, 16 and 32. Inputs are exhaustive at width 4, with directed full-propagate, all-generate and sign-boundary patterns plus random operands at the wider sizes.

// File: rtl/cla_pkg.sv
package cla_pkg;
    // bits handled by one first-level lookahead group
    localparam int GRP_BITS = 4;

    // per-bit carry terms
    typedef struct packed {
        logic gen;
        logic prop;
    } pg_t;

    function automatic int grp_count(input int width);
        return width / GRP_BITS;
    endfunction
endpackage

// File: rtl/cla_pg_cell.sv
module cla_pg_cell
    import cla_pkg::*;
(
    input  logic bit_a,
    input  logic bit_b,
    output pg_t  term
);
    always_comb begin
        term.gen  = bit_a & bit_b;
        term.prop = bit_a | bit_b;
    end
endmodule

// File: rtl/cla_group4.sv
module cla_group4
    import cla_pkg::*;
(
    input  logic [3:0] gen,
    input  logic [3:0] prop,
    input  logic       grp_cin,
    output logic [3:0] stage_c,
    output logic       grp_gen,
    output logic       grp_prop
);
    // every carry written flat: no term uses a neighbouring stage carry
    always_comb begin
        stage_c[0] = gen[0]
                   | (prop[0] & grp_cin);
        stage_c[1] = gen[1]
                   | (prop[1] & gen[0])
                   | (prop[1] & prop[0] & grp_cin);
        stage_c[2] = gen[2]
                   | (prop[2] & gen[1])
                   | (prop[2] & prop[1] & gen[0])
                   | (prop[2] & prop[1] & prop[0] & grp_cin);
        stage_c[3] = gen[3]
                   | (prop[3] & gen[2])
                   | (prop[3] & prop[2] & gen[1])
                   | (prop[3] & prop[2] & prop[1] & gen[0])
                   | (prop[3] & prop[2] & prop[1] & prop[0] & grp_cin);
        grp_gen    = gen[3]
                   | (prop[3] & gen[2])
                   | (prop[3] & prop[2] & gen[1])
                   | (prop[3] & prop[2] & prop[1] & gen[0]);
        grp_prop   = &prop;
    end
endmodule

// File: rtl/cla_group_carry.sv
module cla_group_carry #(
    parameter int NUM_GRP = 8
) (
    input  logic [NUM_GRP-1:0] grp_gen,
    input  logic [NUM_GRP-1:0] grp_prop,
    input  logic               blk_cin,
    output logic [NUM_GRP:0]   grp_c_d
);
    // grp_c_d[j] is the carry into group j; grp_c_d[NUM_GRP] leaves the block.
    // Each one is a flat OR of product terms reaching back to blk_cin.
    always_comb begin
        logic acc;
        logic prod;
        grp_c_d[0] = blk_cin;
        for (int j = 1; j <= NUM_GRP; j++) begin
            prod = blk_cin;
            for (int m = 0; m < j; m++) prod = prod & grp_prop[m];
            acc = prod;
            for (int k = 0; k < j; k++) begin
                prod = grp_gen[k];
                for (int m = k + 1; m < j; m++) prod = prod & grp_prop[m];
                acc = acc | prod;
            end
            grp_c_d[j] = acc;
        end
    end
endmodule

// File: rtl/cla_sum_gen.sv
module cla_sum_gen
    import cla_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  pg_t  [WIDTH-1:0] terms,
    input  logic [WIDTH-1:0] c_into,
    output logic [WIDTH-1:0] sum_d
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum_d[i] = terms[i].gen ^ terms[i].prop ^ c_into[i];
    end
endmodule

// File: rtl/cla_adder.sv
module cla_adder
    import cla_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             carry_msb_in
);
    localparam int NUM_GRP = grp_count(WIDTH);

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             cout;
        logic             cmsb;
    } res_t;

    pg_t  [WIDTH-1:0]   terms;
    logic [WIDTH-1:0]   stage_c;
    logic [WIDTH-1:0]   c_into;
    logic [NUM_GRP-1:0] grp_gen;
    logic [NUM_GRP-1:0] grp_prop;
    logic [NUM_GRP:0]   grp_c_d;
    logic [WIDTH-1:0]   sum_d;
    res_t               res_d;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pg
        cla_pg_cell u_pg (
            .bit_a (op_a[i]),
            .bit_b (op_b[i]),
            .term  (terms[i])
        );
    end

    for (genvar j = 0; j < NUM_GRP; j++) begin : g_grp
        logic [3:0] gj;
        logic [3:0] pj;
        for (genvar b = 0; b < GRP_BITS; b++) begin : g_split
            assign gj[b] = terms[j*GRP_BITS + b].gen;
            assign pj[b] = terms[j*GRP_BITS + b].prop;
        end
        cla_group4 u_grp (
            .gen      (gj),
            .prop     (pj),
            .grp_cin  (grp_c_d[j]),
            .stage_c  (stage_c[j*GRP_BITS +: GRP_BITS]),
            .grp_gen  (grp_gen[j]),
            .grp_prop (grp_prop[j])
        );
    end

    cla_group_carry #(.NUM_GRP(NUM_GRP)) u_gc (
        .grp_gen  (grp_gen),
        .grp_prop (grp_prop),
        .blk_cin  (carry_in),
        .grp_c_d  (grp_c_d)
    );

    assign c_into = {stage_c[WIDTH-2:0], carry_in};

    cla_sum_gen #(.WIDTH(WIDTH)) u_sum (
        .terms  (terms),
        .c_into (c_into),
        .sum_d  (sum_d)
    );

    always_comb begin
        res_d.sum  = sum_d;
        res_d.cout = grp_c_d[NUM_GRP];
        res_d.cmsb = stage_c[WIDTH-2];
    end

    assign sum          = res_d.sum;
    assign carry_out    = res_d.cout;
    assign carry_msb_in = res_d.cmsb;
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out,
    input logic             carry_msb_in
);
    logic [WIDTH:0]   ref_full;
    logic [WIDTH-1:0] ref_low;
    logic             sgn_ovf;

    always_comb begin
        ref_full = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
        ref_low  = {1'b0, op_a[WIDTH-2:0]} + {1'b0, op_b[WIDTH-2:0]}
                 + {{(WIDTH-1){1'b0}}, carry_in};
        sgn_ovf  = (op_a[WIDTH-1] == op_b[WIDTH-1]) && (sum[WIDTH-1] != op_a[WIDTH-1]);

        assert_sum_R1: assert (sum == ref_full[WIDTH-1:0])
            else $error("R1 sum mismatch");
        assert_cout_R2: assert (carry_out == ref_full[WIDTH])
            else $error("R2 carry_out mismatch");
        assert_msb_carry_R3: assert (carry_msb_in == ref_low[WIDTH-1])
            else $error("R3 carry into msb mismatch");
        assert_msb_sum_R3: assert (sum[WIDTH-1] == (op_a[WIDTH-1] ^ op_b[WIDTH-1] ^ carry_msb_in))
            else $error("R3 top sum bit disagrees with exposed carry");
        assert_no_overflow_R4: assert ((carry_out ^ carry_msb_in) == sgn_ovf)
            else $error("R4 overflow indication mismatch");
        if ((op_a ^ op_b) == {WIDTH{1'b1}}) begin
            assert_pass_R5: assert (carry_out == carry_in)
                else $error("R5 carry did not pass through");
        end
    end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a         (op_a),
    .op_b         (op_b),
    .carry_in     (carry_in),
    .sum          (sum),
    .carry_out    (carry_out),
    .carry_msb_in (carry_msb_in)
);

// File: tb/cla_adder_test.sv
module cla_adder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [31:0] a_in = '0;
    logic [31:0] b_in = '0;
    logic        c_in = 1'b0;

    logic [3:0]  s4;
    logic [15:0] s16;
    logic [31:0] s32;
    logic co4, co16, co32, cm4, cm16, cm32;

    cla_adder #(.WIDTH(4)) uut_w4 (
        .op_a(a_in[3:0]), .op_b(b_in[3:0]), .carry_in(c_in),
        .sum(s4), .carry_out(co4), .carry_msb_in(cm4));
    cla_adder #(.WIDTH(16)) uut_w16 (
        .op_a(a_in[15:0]), .op_b(b_in[15:0]), .carry_in(c_in),
        .sum(s16), .carry_out(co16), .carry_msb_in(cm16));
    cla_adder #(.WIDTH(32)) uut (
        .op_a(a_in), .op_b(b_in), .carry_in(c_in),
        .sum(s32), .carry_out(co32), .carry_msb_in(cm32));

    typedef struct {
        string       tag;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] esum [3];
        logic        eco  [3];
        logic        ecm  [3];
        logic        eovf [3];
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic int wid(input int k);
        return (k == 0) ? 4 : ((k == 1) ? 16 : 32);
    endfunction

    // expected values from plain arithmetic, per requirement
    task automatic drive(input string tag, input logic [31:0] a,
                         input logic [31:0] b, input logic c);
        item_t it;
        @(posedge clk);
        a_in = a; b_in = b; c_in = c;
        it.tag = tag; it.a = a; it.b = b;
        for (int k = 0; k < 3; k++) begin
            int w = wid(k);
            logic [63:0] m = (64'd1 << w) - 1;
            logic [63:0] ml = (64'd1 << (w - 1)) - 1;
            logic [63:0] full = (a & m) + (b & m) + c;
            logic [63:0] low = (a & ml) + (b & ml) + c;
            logic sa = a[w-1];
            logic sb = b[w-1];
            logic ss = full[w-1];
            it.esum[k] = full[31:0] & m[31:0];
            it.eco[k]  = full[w];
            it.ecm[k]  = low[w-1];
            it.eovf[k] = (sa == sb) && (ss != sa);
        end
        q.push_back(it);
    endtask

    task automatic cmp(input string req, input string tag, input int w,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) width %0d: actual %h expected %h", req, tag, w, act, exp);
        end
    endtask

    // monitor: compares on the falling edge after each drive
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            item_t it;
            logic [31:0] as [3];
            logic        ac [3];
            logic        am [3];
            it = q.pop_front();
            as[0] = {28'd0, s4}; as[1] = {16'd0, s16}; as[2] = s32;
            ac[0] = co4; ac[1] = co16; ac[2] = co32;
            am[0] = cm4; am[1] = cm16; am[2] = cm32;
            for (int k = 0; k < 3; k++) begin
                cmp("R1", it.tag, wid(k), as[k], it.esum[k]);
                cmp("R2", it.tag, wid(k), {31'd0, ac[k]}, {31'd0, it.eco[k]});
                cmp("R3", it.tag, wid(k), {31'd0, am[k]}, {31'd0, it.ecm[k]});
                cmp("R4", it.tag, wid(k), {31'd0, ac[k] ^ am[k]}, {31'd0, it.eovf[k]});
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R6: all-zero inputs
        drive("R6 zero", 32'd0, 32'd0, 1'b0);
        // R5: full propagate, carry_in 0 and 1
        drive("R5 prop cin0", 32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b0);
        drive("R5 prop cin1", 32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1);
        drive("R5 ones+cin", 32'hFFFF_FFFF, 32'd0, 1'b1);
        // all generate, and sign-boundary patterns for R4
        drive("R2 all gen", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        drive("R4 pos ovf", 32'h7FFF_FFFF, 32'd0, 1'b1);
        drive("R4 neg ovf", 32'h8000_8008, 32'h8000_8008, 1'b0);
        drive("R4 mixed", 32'h7FFF_7FF7, 32'h8000_8008, 1'b1);
        // R7: exhaustive at width 4
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int c = 0; c < 2; c++)
                    drive("R7 exhaustive", 32'(a), 32'(b), c[0]);
        // R7: random at widths 16 and 32
        for (int n = 0; n < 2000; n++)
            drive("R7 random", $urandom, $urandom, 1'($urandom));
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule